// File: doc/BRIEF.md
# Grouped Regulator Enable Sequencer

This block drives the enable lines of thirteen power rails: four step-down converters (buck1 to buck4) and nine linear regulators (ldo1 to ldo9). Each rail has a two-bit mode register. The host sets that register through a simple register write port, which stands in for the serial host bus. A rail can be forced off, forced on, or left to follow a request input from the baseband.

Request-driven switching is allowed only while the supply-valid flag and the chip enable pin are both high. When the request input rises in that state, the sequencer turns on the request-mode rails in four ordered groups. A programmable cycle gap separates the groups. When the request falls, every request-mode rail switches off in the same cycle. The falling edge also reloads the two voltage-select registers of buck1 with their defaults. A state output shows how far the sequence has progressed.

Top module: `rail_group_seq`

## Requirements
- R1: A rising request is acted on only while `supply_ok` and `chip_en` are both high. If either one goes low, the sequencer goes to idle after the next edge and all request-mode rails switch off. Restoring qualification while the request is still high does not restart the sequence.
- R2: `seq_state` reports idle=0, group A=1, B=2, C=3, D=4 and all-up=5. A rising request moves the state 0 to 1 to 2 to 3 to 4 to 5, one step at a time. Each group's enables stay on once set, so the enables accumulate.
- R3: Rail bit index in `rail_en` and in the mode address is buck1=0, buck2=1, buck3=2, buck4=3, ldo1..ldo9=4..12. The groups are: group A is buck3, buck2 and ldo2; group B is buck4, ldo1 and ldo3; group C is ldo5 through ldo8; group D is buck1, ldo4 and ldo9.
- R4: Group A switches on at the edge that samples the rising request. Each later group, and then the all-up state, follows a fixed number of edges later, equal to the gap register (address 13, reset value 64). A gap value of 0 behaves as 1.
- R5: At the edge that samples a low request, every request-mode rail switches off together. This includes a sequence that has not finished, which goes straight to idle.
- R6: Mode encoding is 2'b00 forced off, 2'b01 forced on, 2'b1x follow request. A forced rail holds its level no matter what the request input does.
- R7: At every edge that samples a falling request, `core_vsel0` and `core_vsel1` (addresses 14 and 15) reload their defaults 8'h20 and 8'h2C. This happens whatever buck1's mode is. A low request with no falling edge leaves them unchanged.
- R8: After reset, buck1, ldo1, ldo2, ldo4 and ldo6 are in request mode and every other rail is forced off. The sequencer is idle and all enables are low.
- R9: A mode write takes effect at the edge that captures it. A rail moved into request mode while the sequencer is all-up switches on at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Input supply valid flag |
| chip_en | input | 1 | Chip enable pin |
| req_in | input | 1 | Baseband power request (synchronous) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (4) | Register address: 0..12 rail modes, 13 gap, 14/15 voltage selects |
| wr_data | input | DATA_W (8) | Register write data |
| rail_en | output | 13 | Per-rail enable, bit index as in R3 |
| seq_state | output | 3 | Sequencer state code as in R2 |
| core_vsel0 | output | DATA_W (8) | buck1 voltage-select setting 0 |
| core_vsel1 | output | DATA_W (8) | buck1 voltage-select setting 1 |

## Verification
Every result comes from a register loaded at the rising edge that samples the stimulus. The bench drives inputs on the falling edge and checks on the falling edge that follows the counted rising edges. Group A and the drop on a falling request are due one edge after the request change. Group k+1 is due exactly gap edges after group k, so the bench checks one edge before and one edge at each group boundary. Mode and voltage-select writes are visible at the falling edge right after the write cycle.

// File: rtl/rail_seq_pkg.sv
`timescale 1ns/1ps
package rail_seq_pkg;

   localparam int NUM_RAILS  = 13;
   localparam int NUM_GROUPS = 4;

   // rail indices shared by enable vector and mode address space
   localparam int RAIL_BUCK1 = 0;
   localparam int RAIL_BUCK2 = 1;
   localparam int RAIL_BUCK3 = 2;
   localparam int RAIL_BUCK4 = 3;
   localparam int RAIL_LDO1  = 4;
   localparam int RAIL_LDO2  = 5;
   localparam int RAIL_LDO3  = 6;
   localparam int RAIL_LDO4  = 7;
   localparam int RAIL_LDO5  = 8;
   localparam int RAIL_LDO6  = 9;
   localparam int RAIL_LDO7  = 10;
   localparam int RAIL_LDO8  = 11;
   localparam int RAIL_LDO9  = 12;

   typedef enum logic [2:0] {
      SEQ_IDLE   = 3'd0,
      SEQ_GRP_A  = 3'd1,
      SEQ_GRP_B  = 3'd2,
      SEQ_GRP_C  = 3'd3,
      SEQ_GRP_D  = 3'd4,
      SEQ_ALL_UP = 3'd5
   } seq_state_t;

   typedef logic [1:0] rail_mode_t;

   localparam rail_mode_t MODE_OFF = 2'b00;
   localparam rail_mode_t MODE_ON  = 2'b01;
   localparam rail_mode_t MODE_REQ = 2'b10;

   // power-up group of each rail (0 = first)
   function automatic logic [1:0] rail_group(input int idx);
      case (idx)
         RAIL_BUCK2, RAIL_BUCK3, RAIL_LDO2:            return 2'd0;
         RAIL_BUCK4, RAIL_LDO1, RAIL_LDO3:             return 2'd1;
         RAIL_LDO5, RAIL_LDO6, RAIL_LDO7, RAIL_LDO8:   return 2'd2;
         default:                                      return 2'd3;
      endcase
   endfunction

   function automatic rail_mode_t rail_reset_mode(input int idx);
      case (idx)
         RAIL_BUCK1, RAIL_LDO1, RAIL_LDO2, RAIL_LDO4, RAIL_LDO6: return MODE_REQ;
         default:                                                return MODE_OFF;
      endcase
   endfunction

endpackage

// File: rtl/rail_mode_regs.sv
`timescale 1ns/1ps
module rail_mode_regs
   import rail_seq_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 8,
   parameter int GAP_W     = 8,
   parameter int GAP_RESET = 64,
   parameter logic [DATA_W-1:0] VSEL0_RESET = 'h20,
   parameter logic [DATA_W-1:0] VSEL1_RESET = 'h2C
)(
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [ADDR_W-1:0]             wr_addr,
   input  logic [DATA_W-1:0]             wr_data,
   input  logic                          req_fall,
   output rail_mode_t [NUM_RAILS-1:0]    mode_vec,
   output logic [GAP_W-1:0]              gap_cfg,
   output logic [DATA_W-1:0]             vsel0,
   output logic [DATA_W-1:0]             vsel1
);

   localparam int NUM_REGS = NUM_RAILS + 3;
   localparam logic [ADDR_W-1:0] ADDR_GAP   = ADDR_W'(NUM_RAILS);
   localparam logic [ADDR_W-1:0] ADDR_VSEL0 = ADDR_W'(NUM_RAILS + 1);
   localparam logic [ADDR_W-1:0] ADDR_VSEL1 = ADDR_W'(NUM_RAILS + 2);

   if (ADDR_W < $clog2(NUM_REGS)) begin : g_bad_addr_w
      $error("ADDR_W too narrow for register map");
   end
   if (GAP_W > DATA_W) begin : g_bad_gap_w
      $error("GAP_W must not exceed DATA_W");
   end
   if (DATA_W < 2) begin : g_bad_data_w
      $error("DATA_W must hold a mode field");
   end
   if (GAP_RESET >= (1 << GAP_W)) begin : g_bad_gap_reset
      $error("GAP_RESET does not fit GAP_W");
   end

   for (genvar i = 0; i < NUM_RAILS; i++) begin : g_mode
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(i);
      rail_mode_t m_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            m_q <= rail_reset_mode(i);
         else if (wr_en && (wr_addr == MY_ADDR))
            m_q <= wr_data[1:0];
      end
      assign mode_vec[i] = m_q;
   end

   logic [GAP_W-1:0]  gap_q;
   logic [DATA_W-1:0] vsel0_q, vsel1_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         gap_q <= GAP_W'(GAP_RESET);
      else if (wr_en && (wr_addr == ADDR_GAP))
         gap_q <= wr_data[GAP_W-1:0];
   end

   // falling request wins over a same-cycle host write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vsel0_q <= VSEL0_RESET;
         vsel1_q <= VSEL1_RESET;
      end else if (req_fall) begin
         vsel0_q <= VSEL0_RESET;
         vsel1_q <= VSEL1_RESET;
      end else if (wr_en) begin
         if (wr_addr == ADDR_VSEL0) vsel0_q <= wr_data;
         if (wr_addr == ADDR_VSEL1) vsel1_q <= wr_data;
      end
   end

   assign gap_cfg = gap_q;
   assign vsel0   = vsel0_q;
   assign vsel1   = vsel1_q;

endmodule

// File: rtl/rail_seq_fsm.sv
`timescale 1ns/1ps
module rail_seq_fsm
   import rail_seq_pkg::*;
#(
   parameter int GAP_W = 8
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   qualified,
   input  logic                   req_in,
   input  logic [GAP_W-1:0]       gap_cfg,
   output logic                   req_fall,
   output logic [NUM_GROUPS-1:0]  grp_on,
   output seq_state_t             state
);

   logic                  req_q;
   logic                  req_rise;
   seq_state_t            state_q;
   logic [NUM_GROUPS-1:0] grp_q;
   logic [GAP_W-1:0]      cnt_q;
   logic [GAP_W-1:0]      gap_load;

   assign req_rise = req_in & ~req_q;
   assign req_fall = ~req_in & req_q;
   // a zero gap is clamped to a one-cycle spacing
   assign gap_load = (gap_cfg == '0) ? '0 : gap_cfg - GAP_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q   <= 1'b0;
         state_q <= SEQ_IDLE;
         grp_q   <= '0;
         cnt_q   <= '0;
      end else begin
         req_q <= req_in;
         if (!qualified || req_fall) begin
            state_q <= SEQ_IDLE;
            grp_q   <= '0;
            cnt_q   <= '0;
         end else begin
            case (state_q)
               SEQ_IDLE: begin
                  if (req_rise) begin
                     state_q <= SEQ_GRP_A;
                     grp_q   <= NUM_GROUPS'(1);
                     cnt_q   <= gap_load;
                  end
               end
               SEQ_GRP_A, SEQ_GRP_B, SEQ_GRP_C, SEQ_GRP_D: begin
                  if (cnt_q == '0) begin
                     state_q <= seq_state_t'(state_q + 3'd1);
                     grp_q   <= {grp_q[NUM_GROUPS-2:0], 1'b1};
                     cnt_q   <= gap_load;
                  end else begin
                     cnt_q <= cnt_q - GAP_W'(1);
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign grp_on = grp_q;
   assign state  = state_q;

endmodule

// File: rtl/rail_en_mux.sv
`timescale 1ns/1ps
module rail_en_mux
   import rail_seq_pkg::*;
(
   input  rail_mode_t [NUM_RAILS-1:0] mode_vec,
   input  logic [NUM_GROUPS-1:0]      grp_on,
   output logic [NUM_RAILS-1:0]       rail_en
);

   for (genvar i = 0; i < NUM_RAILS; i++) begin : g_rail
      localparam logic [1:0] GRP = rail_group(i);
      assign rail_en[i] = mode_vec[i][1] ? grp_on[GRP] : mode_vec[i][0];
   end

endmodule

// File: rtl/rail_group_seq.sv
`timescale 1ns/1ps
module rail_group_seq
   import rail_seq_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 8,
   parameter int GAP_W     = 8,
   parameter int GAP_RESET = 64,
   parameter logic [DATA_W-1:0] VSEL0_RESET = 'h20,
   parameter logic [DATA_W-1:0] VSEL1_RESET = 'h2C
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  supply_ok,
   input  logic                  chip_en,
   input  logic                  req_in,
   input  logic                  wr_en,
   input  logic [ADDR_W-1:0]     wr_addr,
   input  logic [DATA_W-1:0]     wr_data,
   output logic [NUM_RAILS-1:0]  rail_en,
   output logic [2:0]            seq_state,
   output logic [DATA_W-1:0]     core_vsel0,
   output logic [DATA_W-1:0]     core_vsel1
);

   rail_mode_t [NUM_RAILS-1:0] mode_vec;
   logic [GAP_W-1:0]           gap_cfg;
   logic                       req_fall;
   logic [NUM_GROUPS-1:0]      grp_on;
   seq_state_t                 state;
   logic                       qualified;

   assign qualified = supply_ok & chip_en;

   rail_mode_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GAP_W(GAP_W), .GAP_RESET(GAP_RESET),
      .VSEL0_RESET(VSEL0_RESET), .VSEL1_RESET(VSEL1_RESET)
   ) regs_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .req_fall(req_fall), .mode_vec(mode_vec), .gap_cfg(gap_cfg),
      .vsel0(core_vsel0), .vsel1(core_vsel1)
   );

   rail_seq_fsm #(.GAP_W(GAP_W)) fsm_i (
      .clk(clk), .rst_n(rst_n), .qualified(qualified), .req_in(req_in),
      .gap_cfg(gap_cfg), .req_fall(req_fall), .grp_on(grp_on), .state(state)
   );

   rail_en_mux mux_i (
      .mode_vec(mode_vec), .grp_on(grp_on), .rail_en(rail_en)
   );

   assign seq_state = state;

endmodule

// File: rtl/rail_group_seq_chk.sv
`timescale 1ns/1ps
module rail_group_seq_chk
   import rail_seq_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter logic [DATA_W-1:0] VSEL0_RESET = 'h20,
   parameter logic [DATA_W-1:0] VSEL1_RESET = 'h2C
)(
   input logic                       clk,
   input logic                       rst_n,
   input logic                       supply_ok,
   input logic                       chip_en,
   input logic                       req_in,
   input logic [NUM_RAILS-1:0]       rail_en,
   input logic [2:0]                 seq_state,
   input logic [DATA_W-1:0]          core_vsel0,
   input logic [DATA_W-1:0]          core_vsel1,
   input rail_mode_t [NUM_RAILS-1:0] mode_vec,
   input logic [NUM_GROUPS-1:0]      grp_on
);

   logic [NUM_RAILS-1:0] req_mask;
   logic [NUM_RAILS-1:0] forced_mask;

   for (genvar i = 0; i < NUM_RAILS; i++) begin : g_mask
      assign req_mask[i] = mode_vec[i][1];
   end
   assign forced_mask = ~req_mask;

   // R1
   unqual_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(supply_ok && chip_en) |=> ((seq_state == 3'd0) && ((rail_en & req_mask) == '0)));

   // R2
   state_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_state != $past(seq_state)) |-> ((seq_state == 3'd0) || (seq_state == $past(seq_state) + 3'd1)));

   // R2
   grp_thermo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((grp_on & (grp_on + NUM_GROUPS'(1))) == '0));

   // R5
   req_low_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_in |=> ((rail_en & req_mask) == '0));

   // R6
   forced_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_vec == $past(mode_vec)) |-> ((rail_en & forced_mask) == ($past(rail_en) & forced_mask)));

   // R7
   vsel_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !req_in && $past(req_in)) |=> ((core_vsel0 == VSEL0_RESET) && (core_vsel1 == VSEL1_RESET)));

endmodule

bind rail_group_seq rail_group_seq_chk #(
   .DATA_W(DATA_W), .VSEL0_RESET(VSEL0_RESET), .VSEL1_RESET(VSEL1_RESET)
) chk_i (
   .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .chip_en(chip_en), .req_in(req_in),
   .rail_en(rail_en), .seq_state(seq_state), .core_vsel0(core_vsel0), .core_vsel1(core_vsel1),
   .mode_vec(mode_vec), .grp_on(grp_on)
);

// File: tb/rail_group_seq_tb_top.sv
`timescale 1ns/1ps
module rail_group_seq_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        supply_ok, chip_en, req_in, wr_en;
   logic [3:0]  wr_addr;
   logic [7:0]  wr_data;
   logic [12:0] rail_en;
   logic [2:0]  seq_state;
   logic [7:0]  core_vsel0, core_vsel1;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   rail_group_seq dut_i (
      .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .chip_en(chip_en), .req_in(req_in),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rail_en(rail_en),
      .seq_state(seq_state), .core_vsel0(core_vsel0), .core_vsel1(core_vsel1)
   );

   typedef struct packed {
      logic        req;
      logic [6:0]  cyc;
      logic [2:0]  st;
      logic [12:0] en;
   } vec_t;

   // default modes, gap = 4: group A=0x020, B=0x010, C=0x200, D=0x081
   localparam vec_t VECS [10] = '{
      '{1'b1, 7'd1, 3'd1, 13'h0020},
      '{1'b1, 7'd3, 3'd1, 13'h0020},
      '{1'b1, 7'd1, 3'd2, 13'h0030},
      '{1'b1, 7'd4, 3'd3, 13'h0230},
      '{1'b1, 7'd4, 3'd4, 13'h02B1},
      '{1'b1, 7'd4, 3'd5, 13'h02B1},
      '{1'b0, 7'd1, 3'd0, 13'h0000},
      '{1'b1, 7'd6, 3'd2, 13'h0030},
      '{1'b0, 7'd1, 3'd0, 13'h0000},
      '{1'b0, 7'd3, 3'd0, 13'h0000}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_addr = '0; wr_data = '0;
   endtask

   initial begin
      rst_n = 1'b0; supply_ok = 1'b0; chip_en = 1'b0; req_in = 1'b0;
      wr_en = 1'b0; wr_addr = '0; wr_data = '0;
      step(3);
      rst_n = 1'b1;
      step(1);
      // R8 reset state
      check("R8 rail_en after reset", 32'(rail_en), 32'h0);
      check("R8 state after reset", 32'(seq_state), 32'd0);
      check("R7 vsel0 reset", 32'(core_vsel0), 32'h20);
      check("R7 vsel1 reset", 32'(core_vsel1), 32'h2C);

      // R1 unqualified requests ignored
      chip_en = 1'b1; req_in = 1'b1; step(2);
      check("R1 no supply state", 32'(seq_state), 32'd0);
      check("R1 no supply rails", 32'(rail_en), 32'h0);
      req_in = 1'b0; step(1);
      supply_ok = 1'b1; chip_en = 1'b0; req_in = 1'b1; step(2);
      check("R1 no enable state", 32'(seq_state), 32'd0);
      req_in = 1'b0; chip_en = 1'b1; step(1);

      // R4 default gap of 64
      req_in = 1'b1; step(1);
      check("R4 default gap group A", 32'(seq_state), 32'd1);
      check("R8 default group A rail", 32'(rail_en), 32'h020);
      step(63);
      check("R4 default gap still A", 32'(seq_state), 32'd1);
      step(1);
      check("R4 default gap reaches B", 32'(seq_state), 32'd2);
      check("R4 default gap B rails", 32'(rail_en), 32'h030);
      req_in = 1'b0; step(1);
      check("R5 drop after default gap", 32'(rail_en), 32'h0);

      // table walk with gap 4 (R2 R4 R5 R8)
      wr(4'd13, 8'd4);
      for (int v = 0; v < 10; v++) begin
         req_in = VECS[v].req;
         repeat (VECS[v].cyc) @(negedge clk);
         check($sformatf("R2 table %0d state", v), 32'(seq_state), 32'(VECS[v].st));
         check($sformatf("R5 table %0d rails", v), 32'(rail_en), 32'(VECS[v].en));
      end

      // R1 qualification loss while all up
      req_in = 1'b1; step(20);
      check("R2 all up", 32'(seq_state), 32'd5);
      chip_en = 1'b0; step(1);
      check("R1 loss to idle", 32'(seq_state), 32'd0);
      check("R1 loss rails off", 32'(rail_en), 32'h0);
      chip_en = 1'b1; step(2);
      check("R1 no restart while high", 32'(seq_state), 32'd0);
      req_in = 1'b0; step(1);

      // R6 R9 forced modes
      wr(4'd1, 8'h01);
      check("R9 forced on next clock", 32'(rail_en), 32'h002);
      wr(4'd5, 8'h00);
      req_in = 1'b1; step(20);
      check("R6 forced rails during up", 32'(rail_en), 32'h293);
      req_in = 1'b0; step(1);
      check("R6 forced on survives fall", 32'(rail_en), 32'h002);
      req_in = 1'b1; step(20);
      wr(4'd6, 8'h02);
      check("R9 join while all up", 32'(rail_en), 32'h2D3);
      req_in = 1'b0; step(1);
      check("R6 after second fall", 32'(rail_en), 32'h002);

      // R7 voltage-select reset on fall
      wr(4'd14, 8'h55);
      wr(4'd15, 8'hAA);
      check("R7 vsel0 write", 32'(core_vsel0), 32'h55);
      check("R7 vsel1 write", 32'(core_vsel1), 32'hAA);
      wr(4'd0, 8'h01);
      req_in = 1'b1; step(2);
      check("R6 forced buck1 rails", 32'(rail_en), 32'h003);
      req_in = 1'b0; step(1);
      check("R7 vsel0 after fall", 32'(core_vsel0), 32'h20);
      check("R7 vsel1 after fall", 32'(core_vsel1), 32'h2C);
      check("R6 forced after fall", 32'(rail_en), 32'h003);
      wr(4'd14, 8'h33);
      step(3);
      check("R7 low level keeps vsel", 32'(core_vsel0), 32'h33);

      // R3 group membership with every rail in request mode
      for (int i = 0; i < 13; i++) wr(4'(i), 8'h02);
      check("R3 all request idle", 32'(rail_en), 32'h0);
      req_in = 1'b1; step(1);
      check("R3 group A", 32'(rail_en), 32'h0026);
      step(4);
      check("R3 group B", 32'(rail_en), 32'h007E);
      step(4);
      check("R3 group C", 32'(rail_en), 32'h0F7E);
      step(4);
      check("R3 group D", 32'(rail_en), 32'h1FFF);
      check("R2 state D", 32'(seq_state), 32'd4);
      step(4);
      check("R2 state all up", 32'(seq_state), 32'd5);
      req_in = 1'b0; step(1);
      check("R5 all off at once", 32'(rail_en), 32'h0);

      // R4 gap of zero acts as one
      wr(4'd13, 8'd0);
      req_in = 1'b1; step(1);
      check("R4 gap0 group A", 32'(seq_state), 32'd1);
      step(1);
      check("R4 gap0 group B", 32'(seq_state), 32'd2);
      check("R4 gap0 rails", 32'(rail_en), 32'h007E);
      req_in = 1'b0; step(1);
      check("R5 gap0 drop", 32'(rail_en), 32'h0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

endmodule